// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that belongs to one core. The cache shares a broadcast bus with other caches, and the bus uses invalidation to keep copies consistent. Each line is held in one of four states: Modified, Exclusive, Shared or Invalid. The controller takes read and write requests from the core. When a request needs the bus, the controller raises a request and waits for the arbiter's grant. Only when the grant arrives does it put a read, read-for-ownership, invalidate or writeback transaction on the bus. Every state change that involves other caches therefore happens in the single cycle the bus is owned, and the bus serializes it against the changes made by the other caches.

The controller also watches the transactions that other controllers put on the bus. A foreign read of a line held here raises the shared signal and downgrades the line to Shared. If that line is dirty, the controller also signals that it supplies the data. A foreign read-for-ownership or invalidate removes the local copy. The data array, the replacement choice and the arbiter are outside the block. The `line_state` output gives the data array the state of every line.

An address is split into a tag (the upper bits) and a line index (the low `$clog2(LINES)` bits). Only one core request is outstanding at a time.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid (`line_state` all zero, with 2 bits per line, line i at bits [2i+1:2i], and the encoding Invalid=0, Shared=1, Exclusive=2, Modified=3). `bus_req`, `busy` and `core_done` are low.
- R2: A read miss requests the bus with command read (`bus_cmd`=0) at the requested address. On the grant the line is filled as Exclusive if `bus_shared` is low in the grant cycle, or as Shared if it is high. `core_done` pulses the cycle after the grant.
- R3: A write to an Exclusive or Modified line makes the line Modified and pulses `core_done` one cycle after acceptance. It uses no bus transaction.
- R4: A write to a Shared line requests the bus with command invalidate (`bus_cmd`=2). The line becomes Modified only on the grant.
- R5: A write miss requests the bus with command read-for-ownership (`bus_cmd`=1). The line becomes Modified on the grant.
- R6: A snooped read (`snp_cmd`=0) that hits a valid line raises `snp_shared` in the same cycle and leaves the line Shared. If the line was Modified, `snp_supply` is also raised.
- R7: A snooped read-for-ownership (1) or invalidate (2) that hits makes the line Invalid. A snooped writeback (3), or any snoop with a different tag, leaves the state unchanged and does not raise `snp_shared`.
- R8: A miss whose line holds a Modified copy with another tag first issues a writeback (`bus_cmd`=3) of the old address. The fill follows after that grant. A Shared or Exclusive victim is dropped with no writeback.
- R9: If a pending upgrade of a Shared line is invalidated by a snoop before the grant, the request becomes a read-for-ownership.
- R10: While the request waits without a grant and no snoop arrives, `bus_req`, `bus_cmd`, `bus_addr` and all line states hold.
- R11: A read hit pulses `core_done` one cycle after acceptance, uses no bus transaction and leaves the state unchanged.
- R12: If a pending victim writeback is overtaken by a snooped read (the data is supplied and the line goes Shared), the writeback is dropped and the fill is requested directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request, accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| busy | output | 1 | Request outstanding or snoop in progress |
| core_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_gnt | input | 1 | Grant; the transaction takes place in this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled on grant) |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Foreign command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Foreign transaction address |
| snp_shared | output | 1 | This cache holds the snooped line (read snoop) |
| snp_supply | output | 1 | This cache supplies dirty data for the snooped read |
| line_state | output | 2*LINES | Packed state of every line |

## Verification
The bench drives races where a snoop arrives while a request waits for the grant. If an upgrade whose copy was invalidated still went out as an invalidate, the core would own a line with no data. If a writeback stayed pending after a snoop had already cleaned the line, the bus would carry a second, stale writeback. The eviction tests check that only a dirty victim causes a writeback and that the writeback goes to the victim's address, not the requester's. An incorrect victim choice would lose data or add traffic. Waits without a grant check that a design which changed a line before owning the bus would show the change early.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 busy,
  output logic                 core_done,
  output logic                 bus_req,
  output logic [1:0]           bus_cmd,
  output logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_gnt,
  input  logic                 bus_shared,
  input  logic                 snp_valid,
  input  logic [1:0]           snp_cmd,
  input  logic [ADDR_W-1:0]    snp_addr,
  output logic                 snp_shared,
  output logic                 snp_supply,
  output logic [2*LINES-1:0]   line_state
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3;
  localparam logic [1:0] BC_RD = 2'd0, BC_RFO = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3;

  logic [1:0]       st  [LINES];
  logic [TAG_W-1:0] tag [LINES];

  logic              pend, p_wr, done_q;
  logic [ADDR_W-1:0] p_addr;

  wire [IDX_W-1:0] l_idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] l_tag = req_addr[ADDR_W-1:IDX_W];
  wire [1:0]       l_st  = st[l_idx];
  wire             l_hit = (l_st != LS_I) && (tag[l_idx] == l_tag);

  wire [IDX_W-1:0] p_idx = p_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1:IDX_W];
  wire [1:0]       p_st  = st[p_idx];
  wire             p_hit = (p_st != LS_I) && (tag[p_idx] == p_tag);
  wire             need_wb = (p_st == LS_M) && !p_hit;

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [1:0]       s_st  = st[s_idx];
  wire             s_hit = snp_valid && (s_st != LS_I) && (tag[s_idx] == s_tag);

  wire accept = req_valid && !pend && !snp_valid;

  assign busy       = pend || snp_valid;
  assign core_done  = done_q;
  assign bus_req    = pend;
  assign bus_cmd    = need_wb ? BC_WB :
                      p_wr    ? ((p_hit && p_st == LS_S) ? BC_INV : BC_RFO) :
                                BC_RD;
  assign bus_addr   = need_wb ? {tag[p_idx], p_idx} : p_addr;
  assign snp_shared = s_hit && (snp_cmd == BC_RD);
  assign snp_supply = snp_shared && (s_st == LS_M);

  for (genvar g = 0; g < LINES; g++) begin : g_state
    assign line_state[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i]  <= LS_I;
        tag[i] <= '0;
      end
      pend   <= 1'b0;
      p_wr   <= 1'b0;
      p_addr <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pend && bus_gnt) begin
        case (bus_cmd)
          BC_WB:  st[p_idx] <= LS_I;
          BC_RD: begin
            st[p_idx]  <= bus_shared ? LS_S : LS_E;
            tag[p_idx] <= p_tag;
            pend       <= 1'b0;
            done_q     <= 1'b1;
          end
          default: begin
            st[p_idx]  <= LS_M;
            tag[p_idx] <= p_tag;
            pend       <= 1'b0;
            done_q     <= 1'b1;
          end
        endcase
      end else begin
        if (s_hit) begin
          case (snp_cmd)
            BC_RD:          st[s_idx] <= LS_S;
            BC_RFO, BC_INV: st[s_idx] <= LS_I;
            default:        ;
          endcase
        end
        if (accept) begin
          if (l_hit && !req_write) begin
            done_q <= 1'b1;
          end else if (l_hit && (l_st == LS_E || l_st == LS_M)) begin
            st[l_idx] <= LS_M;
            done_q    <= 1'b1;
          end else begin
            pend   <= 1'b1;
            p_wr   <= req_write;
            p_addr <= req_addr;
            if (!l_hit && (l_st == LS_S || l_st == LS_E))
              st[l_idx] <= LS_I;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_gnt,
  input logic [1:0]         bus_cmd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               snp_valid,
  input logic               snp_shared,
  input logic               snp_supply,
  input logic               core_done,
  input logic [2*LINES-1:0] line_state
);
  logic any_s, any_m;
  always_comb begin
    any_s = 1'b0;
    any_m = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (line_state[2*i +: 2] == 2'd1) any_s = 1'b1;
      if (line_state[2*i +: 2] == 2'd3) any_m = 1'b1;
    end
  end

  assert_wait_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_valid |=>
      bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(line_state));

  assert_supply_implies_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);

  assert_upgrade_from_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cmd == 2'd2 |-> any_s);

  assert_wb_from_modified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cmd == 2'd3 |-> any_m);

  assert_fill_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'd0 |=> core_done && !bus_req);

  assert_own_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && (bus_cmd == 2'd1 || bus_cmd == 2'd2) |=> core_done && any_m);

  assert_wb_not_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'd3 |=> !core_done && bus_req);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid),
  .snp_shared(snp_shared), .snp_supply(snp_supply), .core_done(core_done),
  .line_state(line_state)
);

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  localparam int LINES = 4, ADDR_W = 8;
  localparam int I = 0, S = 1, E = 2, M = 3;
  localparam int RD = 0, RFO = 1, INV = 2, WB = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic busy, core_done, bus_req, snp_shared, snp_supply;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 0, bus_shared = 0, snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [2*LINES-1:0] line_state;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .busy(busy), .core_done(core_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .line_state(line_state));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st_of(int i);
    return int'(line_state[2*i +: 2]);
  endfunction

  task automatic request(bit wr, logic [ADDR_W-1:0] a);
    req_valid = 1; req_write = wr; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
  endtask

  task automatic grant(bit shr);
    bus_gnt = 1; bus_shared = shr;
    @(posedge clk); @(negedge clk);
    bus_gnt = 0; bus_shared = 0;
  endtask

  task automatic bus_expect(string req, int cmd, int a);
    check({req, " bus_req"}, bus_req, 1);
    check({req, " bus_cmd"}, bus_cmd, cmd);
    check({req, " bus_addr"}, bus_addr, a);
  endtask

  task automatic snoop(string req, int cmd, logic [ADDR_W-1:0] a, int shr, int sup);
    snp_valid = 1; snp_cmd = cmd[1:0]; snp_addr = a;
    #1;
    check({req, " snp_shared"}, snp_shared, shr);
    check({req, " snp_supply"}, snp_supply, sup);
    @(posedge clk); @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 line_state", int'(line_state), 0);
    check("R1 bus_req", bus_req, 0);
    check("R1 busy", busy, 0);
    check("R1 core_done", core_done, 0);
  endtask

  task automatic t_read_miss;
    request(0, 8'h10);
    bus_expect("R2 miss excl", RD, 8'h10);
    grant(0);
    check("R2 done", core_done, 1);
    check("R2 exclusive fill", st_of(0), E);
    request(0, 8'h21);
    bus_expect("R2 miss shared", RD, 8'h21);
    grant(1);
    check("R2 shared fill", st_of(1), S);
    check("R2 idle after fill", bus_req, 0);
  endtask

  task automatic t_silent_write;
    request(1, 8'h10);
    check("R3 done", core_done, 1);
    check("R3 no bus", bus_req, 0);
    check("R3 modified", st_of(0), M);
  endtask

  task automatic t_read_hit;
    request(0, 8'h21);
    check("R11 done", core_done, 1);
    check("R11 no bus", bus_req, 0);
    check("R11 state kept", st_of(1), S);
  endtask

  task automatic t_upgrade;
    request(1, 8'h21);
    bus_expect("R4 upgrade", INV, 8'h21);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 still shared", st_of(1), S);
      check("R10 no done", core_done, 0);
    end
    bus_expect("R10 held", INV, 8'h21);
    grant(0);
    check("R4 modified", st_of(1), M);
    check("R4 done", core_done, 1);
  endtask

  task automatic t_write_miss;
    request(1, 8'h42);
    bus_expect("R5 miss", RFO, 8'h42);
    grant(1);
    check("R5 modified", st_of(2), M);
    check("R5 done", core_done, 1);
  endtask

  task automatic t_snoop_read;
    snoop("R6 dirty", RD, 8'h10, 1, 1);
    check("R6 dirty to shared", st_of(0), S);
    request(0, 8'h13);
    grant(0);
    check("R6 setup exclusive", st_of(3), E);
    snoop("R6 clean", RD, 8'h13, 1, 0);
    check("R6 exclusive to shared", st_of(3), S);
  endtask

  task automatic t_snoop_inv;
    snoop("R7 inv", INV, 8'h21, 0, 0);
    check("R7 invalid", st_of(1), I);
    snoop("R7 wb ignored", WB, 8'h42, 0, 0);
    check("R7 wb state", st_of(2), M);
    snoop("R7 other tag", RFO, 8'h06, 0, 0);
    check("R7 other tag state", st_of(2), M);
    snoop("R7 other tag read", RD, 8'h06, 0, 0);
    check("R7 other tag read state", st_of(2), M);
  endtask

  task automatic t_evict;
    request(0, 8'h82);
    bus_expect("R8 writeback", WB, 8'h42);
    grant(0);
    check("R8 victim cleared", st_of(2), I);
    check("R8 no early done", core_done, 0);
    bus_expect("R8 fill", RD, 8'h82);
    grant(0);
    check("R8 filled", st_of(2), E);
    request(0, 8'h50);
    bus_expect("R8 silent evict", RD, 8'h50);
    grant(0);
    check("R8 new line", st_of(0), E);
  endtask

  task automatic t_upgrade_race;
    request(1, 8'h13);
    bus_expect("R9 first", INV, 8'h13);
    snoop("R9 snoop", INV, 8'h13, 0, 0);
    check("R9 lost copy", st_of(3), I);
    bus_expect("R9 retarget", RFO, 8'h13);
    grant(0);
    check("R9 modified", st_of(3), M);
  endtask

  task automatic t_wb_cancel;
    request(0, 8'h33);
    bus_expect("R12 wb", WB, 8'h13);
    snoop("R12 snoop", RD, 8'h13, 1, 1);
    bus_expect("R12 direct fill", RD, 8'h33);
    grant(1);
    check("R12 filled shared", st_of(3), S);
    check("R12 done", core_done, 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_silent_write();
    t_read_hit();
    t_upgrade();
    t_write_miss();
    t_snoop_read();
    t_snoop_inv();
    t_evict();
    t_upgrade_race();
    t_wb_cancel();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule